// File: doc/BRIEF.md
# Signed Multiply / Divide / Accumulate Unit

This block is an arithmetic helper that sits on a simple byte-wide register bus. Software selects an operation through a control register, writes two 16-bit operands a byte at a time, and the write of the upper byte of the second operand starts the operation. The unit runs an iterative, most-significant-bit-first datapath for a fixed number of cycles. It then raises a valid flag and exposes the result as a row of bytes at consecutive read addresses.

Three operations are available. Signed multiply returns a 32-bit product. Divide takes a signed dividend and an unsigned divisor and works on magnitudes, so the quotient takes the dividend's sign and the remainder stays unsigned. A fixed, well-defined answer comes out when the divisor is zero. Multiply-accumulate adds each signed product into a 40-bit running sum and keeps a sticky overflow flag. The accumulate selection overrides the divide selection. Writing the control register clears the sum.

Top module: `arith_coproc`

## Requirements
- R1: After reset, busy and valid are low and every read address returns 0x00.
- R2: Write address 0 is the control register, addresses 1/2 are the low/high bytes of operand A, and addresses 3/4 are the low/high bytes of operand B. A write to address 4 starts an operation using the new high byte of B.
- R3: busy is high from the clock edge that takes the starting write. valid rises, and busy falls, exactly 5 clock edges after that edge.
- R4: With control bits 1:0 = 00, the result is the signed 32-bit product A*B at read addresses 0..3, low byte first. Address 4 holds the sign extension of the product (0x00 or 0xFF).
- R5: With control bits 1:0 = 01, the quotient is trunc(|A|/B) with the sign of A, at read addresses 0..1. The remainder is |A| mod B, unsigned, at addresses 2..3. Address 4 reads 0x00.
- R6: Divide by zero gives a remainder of |A| (two's-complement negate when A bit 15 is set). The quotient is 0xFFFF for non-negative A and 0x0001 for negative A.
- R7: With control bit 1 set, each operation adds the signed product A*B into a 40-bit accumulator, whatever bit 0 holds. Read addresses 0..4 show the updated sum, low byte first.
- R8: Any write to the control register clears the accumulator and the overflow flag.
- R9: Read address 5 bit 0 is a sticky flag. It is set when a signed 40-bit accumulate overflows and stays set until the next control write.
- R10: A start while busy abandons the running operation. The result is computed from the new operands, and valid rises 5 edges after the newest start.
- R11: Control bits 7:2 have no effect on the operation performed.
- R12: rd_data is 0x00 when rd_en is low, and 0x00 at read addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte (combinational) |
| busy | output | 1 | Operation in progress |
| valid | output | 1 | Result registers hold a completed result |

## Verification
The bench targets the divide corner cases: a dividend of 0x8000, a divisor larger than |A|, and a zero divisor for both dividend signs. A design that took the dividend as unsigned, or signed the remainder, would return 0x0000/0x8000-style errors on these. A design that forgot to negate the quotient for a zero divisor would return 0xFFFF for negative inputs. The accumulator is driven to exactly 2^39 with 512 products of 0x8000*0x8000, so a missing or non-sticky overflow flag, or a wrong wrap width, shows up there. Restarting mid-operation and setting both mode bits together also get directed checks, which expose a stale-operand result or a divide taking priority over accumulate.

// File: rtl/arith_pkg.sv
// Package: shared operation encoding for the arithmetic unit.
// Assumes: control bits 1:0 decide the operation, accumulate dominates.
package arith_pkg;
    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_DIV = 2'd1,
        OP_MAC = 2'd2
    } arith_op_e;
endpackage

// File: rtl/arith_mode_dec.sv
// Module: holds the two meaningful control bits and decodes them to an
// operation. Upper written bits are dropped. Every write produces a
// clear pulse for the accumulator.
module arith_mode_dec
    import arith_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_data,
    output arith_op_e  op,
    output logic       acc_clr
);
    logic [1:0] sel_q;

    // Keep only the divide and accumulate select bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= 2'b00;
        else if (ctrl_wr) sel_q <= ctrl_data[1:0];
    end

    // Accumulate wins over divide; neither bit means multiply.
    always_comb begin
        if (sel_q[1])      op = OP_MAC;
        else if (sel_q[0]) op = OP_DIV;
        else               op = OP_MUL;
    end

    assign acc_clr = ctrl_wr;

    // R7
    mac_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_data[1] |=> op == OP_MAC);
endmodule

// File: rtl/arith_engine.sv
// Module: iterative MSB-first datapath shared by multiply and divide.
// It latches operand magnitudes at start, then processes STEP_BITS bits
// per cycle for OPW/STEP_BITS cycles, and raises fin for one cycle.
// Assumes: OPW is a multiple of STEP_BITS; a start reloads at any time.
module arith_engine
    import arith_pkg::*;
#(
    parameter int OPW       = 16,
    parameter int STEP_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  arith_op_e        op_in,
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic             run,
    output logic             fin,
    output arith_op_e        op_out,
    output logic             neg,
    output logic [2*OPW-1:0] prod,
    output logic [OPW-1:0]   quo,
    output logic [OPW-1:0]   rem
);
    localparam int NSTEPS = OPW / STEP_BITS;
    localparam int CW     = $clog2(NSTEPS + 1);

    logic [CW-1:0]    cnt_q;
    logic [OPW-1:0]   shf_q, dvs_q, quo_q, rem_q;
    logic [2*OPW-1:0] prod_q;
    logic             neg_q;
    arith_op_e        op_q;

    logic [OPW-1:0]   mag_a, mag_b;
    logic [OPW-1:0]   shf_n, quo_n, rem_n;
    logic [2*OPW-1:0] prod_n;

    // Operand magnitudes; a divisor is taken as unsigned.
    always_comb begin
        mag_a = op_a[OPW-1] ? (~op_a + 1'b1) : op_a;
        mag_b = (op_in == OP_DIV) ? op_b
              : (op_b[OPW-1] ? (~op_b + 1'b1) : op_b);
    end

    // One cycle of STEP_BITS shift-add and restoring-subtract steps.
    always_comb begin
        logic [OPW:0] r;
        logic         b;
        shf_n  = shf_q;
        prod_n = prod_q;
        quo_n  = quo_q;
        r      = {1'b0, rem_q};
        for (int i = 0; i < STEP_BITS; i++) begin
            b      = shf_n[OPW-1];
            shf_n  = {shf_n[OPW-2:0], 1'b0};
            prod_n = {prod_n[2*OPW-2:0], 1'b0} + (b ? {{OPW{1'b0}}, dvs_q} : '0);
            r      = {r[OPW-1:0], b};
            if (r >= {1'b0, dvs_q}) begin
                r     = r - {1'b0, dvs_q};
                quo_n = {quo_n[OPW-2:0], 1'b1};
            end else begin
                quo_n = {quo_n[OPW-2:0], 1'b0};
            end
        end
        rem_n = r[OPW-1:0];
    end

    // Sequence control: load on start, step, then hold for finalize.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            cnt_q  <= '0;
            shf_q  <= '0;
            dvs_q  <= '0;
            prod_q <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            neg_q  <= 1'b0;
            op_q   <= OP_MUL;
        end else if (start) begin
            run    <= 1'b1;
            cnt_q  <= '0;
            shf_q  <= mag_a;
            dvs_q  <= mag_b;
            prod_q <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            neg_q  <= (op_in == OP_DIV) ? op_a[OPW-1] : (op_a[OPW-1] ^ op_b[OPW-1]);
            op_q   <= op_in;
        end else if (run) begin
            if (cnt_q == CW'(NSTEPS)) begin
                run <= 1'b0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                shf_q  <= shf_n;
                prod_q <= prod_n;
                quo_q  <= quo_n;
                rem_q  <= rem_n;
            end
        end
    end

    assign fin    = run && (cnt_q == CW'(NSTEPS)) && !start;
    assign op_out = op_q;
    assign neg    = neg_q;
    assign prod   = prod_q;
    assign quo    = quo_q;
    assign rem    = rem_q;

    // R5
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin && op_q == OP_DIV && dvs_q != '0 |-> rem_q < dvs_q);
    // R6
    zero_div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin && op_q == OP_DIV && dvs_q == '0 |-> quo_q == '1);
endmodule

// File: rtl/arith_result.sv
// Module: applies the sign to the raw magnitude results, runs the
// accumulator with its sticky overflow flag, and holds the readable
// result register.
// Assumes: fin lasts one cycle; a clear in the same cycle wins for the
// accumulator state.
module arith_result
    import arith_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int ACCW = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fin,
    input  arith_op_e        op,
    input  logic             neg,
    input  logic [2*OPW-1:0] prod,
    input  logic [OPW-1:0]   quo,
    input  logic [OPW-1:0]   rem,
    output logic [ACCW-1:0]  res,
    output logic             ovf
);
    localparam int EXTW = ACCW - 2 * OPW;

    logic [2*OPW-1:0] prod_s;
    logic [OPW-1:0]   quo_s;
    logic [ACCW-1:0]  prod_x, acc_q, sum;
    logic             ov_now;

    // Signed product and quotient plus the accumulator sum.
    always_comb begin
        prod_s = neg ? (~prod + 1'b1) : prod;
        quo_s  = neg ? (~quo + 1'b1) : quo;
        prod_x = {{EXTW{prod_s[2*OPW-1]}}, prod_s};
        sum    = acc_q + prod_x;
        ov_now = (acc_q[ACCW-1] == prod_x[ACCW-1]) && (sum[ACCW-1] != acc_q[ACCW-1]);
    end

    // Accumulator and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            ovf   <= 1'b0;
        end else if (fin && op == OP_MAC) begin
            acc_q <= sum;
            ovf   <= ovf | ov_now;
        end
    end

    // Result register loaded when an operation finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
        end else if (fin) begin
            case (op)
                OP_DIV:  res <= {{EXTW{1'b0}}, rem, quo_s};
                OP_MAC:  res <= sum;
                default: res <= prod_x;
            endcase
        end
    end

    // R8
    clear_empties_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_q == '0 && !ovf);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> ovf);
endmodule

// File: rtl/arith_coproc.sv
// Module: top of the arithmetic unit. Decodes the byte bus, holds the
// operand bytes, starts the engine on the write of operand B's upper
// byte, and multiplexes result bytes onto the read port.
// Assumes: reads are combinational and free of side effects.
module arith_coproc
    import arith_pkg::*;
#(
    parameter int OPW       = 16,
    parameter int ACCW      = 40,
    parameter int STEP_BITS = 4,
    parameter int AW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          valid
);
    localparam int RBYTES  = ACCW / 8;
    localparam int LATENCY = OPW / STEP_BITS + 1;
    localparam int LCW     = $clog2(LATENCY + 2);
    localparam int OBYTES  = OPW / 8;

    logic [OPW-1:0]   a_q;
    logic [OPW-9:0]   b_lo_q;
    logic             ctrl_wr, start, fin, run, neg, ovf, acc_clr;
    arith_op_e        op_sel, op_run;
    logic [2*OPW-1:0] prod;
    logic [OPW-1:0]   quo, rem;
    logic [ACCW-1:0]  res;

    assign ctrl_wr = wr_en && (addr == AW'(0));
    assign start   = wr_en && (addr == AW'(2 * OBYTES));

    // Operand A bytes and the lower bytes of operand B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_lo_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < OBYTES; i++) begin
                if (addr == AW'(1 + i)) a_q[i*8 +: 8] <= wr_data;
            end
            for (int i = 0; i < OBYTES - 1; i++) begin
                if (addr == AW'(1 + OBYTES + i)) b_lo_q[i*8 +: 8] <= wr_data;
            end
        end
    end

    arith_mode_dec u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (wr_data),
        .op        (op_sel),
        .acc_clr   (acc_clr)
    );

    arith_engine #(.OPW(OPW), .STEP_BITS(STEP_BITS)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_in  (op_sel),
        .op_a   (a_q),
        .op_b   ({wr_data, b_lo_q}),
        .run    (run),
        .fin    (fin),
        .op_out (op_run),
        .neg    (neg),
        .prod   (prod),
        .quo    (quo),
        .rem    (rem)
    );

    arith_result #(.OPW(OPW), .ACCW(ACCW)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .fin   (fin),
        .op    (op_run),
        .neg   (neg),
        .prod  (prod),
        .quo   (quo),
        .rem   (rem),
        .res   (res),
        .ovf   (ovf)
    );

    // Valid flag: dropped on a start, raised when the engine finishes.
    always_ff @(posedge clk) begin
        if (!rst_n || start) valid <= 1'b0;
        else if (fin)        valid <= 1'b1;
    end

    assign busy = run;

    // Read multiplexer: result bytes, then the overflow flag.
    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            for (int i = 0; i < RBYTES; i++) begin
                if (addr == AW'(i)) rd_data = res[i*8 +: 8];
            end
            if (addr == AW'(RBYTES)) rd_data = {7'b0, ovf};
        end
    end

    // Checker counter: cycles since the most recent start.
    logic [LCW-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                        lat_q <= LCW'(LATENCY + 1);
        else if (start)                    lat_q <= '0;
        else if (lat_q != LCW'(LATENCY+1)) lat_q <= lat_q + 1'b1;
    end

    // R3
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> lat_q == LCW'(LATENCY));
    // R3
    busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && valid));
    // R10
    restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && !valid);
endmodule

// File: tb/tb_arith_coproc.sv
module tb_arith_coproc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy, valid;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    arith_coproc dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .busy(busy), .valid(valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic rd_res(output logic [39:0] v);
        logic [7:0] b;
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    // Writes operands; the last write starts. Latency checked when lat=1.
    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit lat);
        bit ok;
        wr(3'd1, a[7:0]); wr(3'd2, a[15:8]); wr(3'd3, b[7:0]); wr(3'd4, b[15:8]);
        ok = 1;
        for (int k = 0; k < 4; k++) begin
            if (valid !== 1'b0 || busy !== 1'b1) ok = 0;
            @(negedge clk);
        end
        if (valid !== 1'b0 || busy !== 1'b1) ok = 0;
        @(negedge clk);
        if (valid !== 1'b1 || busy !== 1'b0) ok = 0;
        if (lat) check("R3 latency", {63'b0, ok}, 64'd1);
    endtask

    function automatic logic [39:0] exp_mul(input logic [15:0] a, input logic [15:0] b);
        int pa, pb;
        logic [31:0] p;
        pa = int'($signed(a)); pb = int'($signed(b));
        p = 32'(pa * pb);
        return {{8{p[31]}}, p};
    endfunction

    function automatic logic [39:0] exp_div(input logic [15:0] a, input logic [15:0] b);
        int unsigned mag, q, r;
        logic [15:0] qs;
        mag = a[15] ? (32'd65536 - 32'(a)) : 32'(a);
        if (b == 16'h0) begin
            r = mag; qs = a[15] ? 16'h0001 : 16'hFFFF;
        end else begin
            q = mag / 32'(b); r = mag % 32'(b);
            qs = a[15] ? 16'(-q) : 16'(q);
        end
        return {8'h00, 16'(r), qs};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] v, macc;
        logic [7:0]  b8;
        logic [15:0] ra, rb;
        bit          movf;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {63'b0, busy}, 64'd0);
        check("R1 valid", {63'b0, valid}, 64'd0);
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), b8);
            check("R1 read zero", {56'b0, b8}, 64'd0);
        end

        // R2 R4 multiply, directed then random
        wr(3'd0, 8'h00);
        run_op(16'h8000, 16'h8000, 1); rd_res(v); check("R4 mul 8000*8000", {24'b0, v}, {24'b0, exp_mul(16'h8000, 16'h8000)});
        run_op(16'hFFFF, 16'h0003, 1); rd_res(v); check("R4 mul -1*3", {24'b0, v}, {24'b0, exp_mul(16'hFFFF, 16'h0003)});
        run_op(16'h7FFF, 16'h8000, 0); rd_res(v); check("R4 mul max*min", {24'b0, v}, {24'b0, exp_mul(16'h7FFF, 16'h8000)});
        for (int i = 0; i < 30; i++) begin
            ra = 16'($urandom); rb = 16'($urandom);
            run_op(ra, rb, (i < 3)); rd_res(v);
            check("R2 R4 mul random", {24'b0, v}, {24'b0, exp_mul(ra, rb)});
        end

        // R11 upper control bits ignored: 0xFC is multiply, 0x7D is divide
        wr(3'd0, 8'hFC);
        run_op(16'h1234, 16'hFFF0, 0); rd_res(v); check("R11 mul with junk bits", {24'b0, v}, {24'b0, exp_mul(16'h1234, 16'hFFF0)});
        wr(3'd0, 8'h7D);
        run_op(16'h1234, 16'h0010, 0); rd_res(v); check("R11 div with junk bits", {24'b0, v}, {24'b0, exp_div(16'h1234, 16'h0010)});

        // R5 divide corner cases
        wr(3'd0, 8'h01);
        run_op(16'h8000, 16'h0101, 1); rd_res(v); check("R5 div 8000/0101", {24'b0, v}, {24'b0, 40'h00_0081_FF81});
        run_op(16'h8000, 16'h8000, 0); rd_res(v); check("R5 div 8000/8000", {24'b0, v}, {24'b0, 40'h00_0000_FFFF});
        run_op(16'h87F8, 16'hFFFB, 0); rd_res(v); check("R5 div divisor>mag", {24'b0, v}, {24'b0, 40'h00_7808_0000});
        run_op(16'h53FE, 16'h0037, 0); rd_res(v); check("R5 div positive", {24'b0, v}, {24'b0, 40'h00_0034_0186});
        // R6 divide by zero
        run_op(16'h87F8, 16'h0000, 0); rd_res(v); check("R6 div0 negative", {24'b0, v}, {24'b0, 40'h00_7808_0001});
        run_op(16'h7FF8, 16'h0000, 0); rd_res(v); check("R6 div0 positive", {24'b0, v}, {24'b0, 40'h00_7FF8_FFFF});
        run_op(16'h8000, 16'h0000, 0); rd_res(v); check("R6 div0 min", {24'b0, v}, {24'b0, 40'h00_8000_0001});
        for (int i = 0; i < 30; i++) begin
            ra = 16'($urandom); rb = (i % 5 == 0) ? 16'($urandom % 8) : 16'($urandom);
            run_op(ra, rb, 0); rd_res(v);
            check("R5 R6 div random", {24'b0, v}, {24'b0, exp_div(ra, rb)});
        end

        // R7 accumulate with divide bit also set
        wr(3'd0, 8'h03);
        macc = '0; movf = 0;
        for (int i = 0; i < 20; i++) begin
            ra = 16'($urandom); rb = 16'($urandom);
            run_op(ra, rb, 0);
            macc = macc + exp_mul(ra, rb);
            rd_res(v);
            check("R7 mac sum", {24'b0, v}, {24'b0, macc});
        end

        // R8 R9 overflow at 2^39 then sticky, then clear
        wr(3'd0, 8'h02);
        for (int i = 0; i < 511; i++) run_op(16'h8000, 16'h8000, 0);
        rd(3'd5, b8); check("R9 no ovf at 511", {56'b0, b8}, 64'd0);
        rd_res(v); check("R7 sum at 511", {24'b0, v}, {24'b0, 40'h7F_C000_0000});
        run_op(16'h8000, 16'h8000, 0);
        rd(3'd5, b8); check("R9 ovf at 512", {56'b0, b8}, 64'd1);
        rd_res(v); check("R9 wrap value", {24'b0, v}, {24'b0, 40'h80_0000_0000});
        run_op(16'h0002, 16'h0003, 0);
        rd(3'd5, b8); check("R9 ovf sticky", {56'b0, b8}, 64'd1);
        wr(3'd0, 8'h02);
        rd(3'd5, b8); check("R8 ovf cleared", {56'b0, b8}, 64'd0);
        run_op(16'h0002, 16'h0003, 0); rd_res(v);
        check("R8 acc cleared", {24'b0, v}, {24'b0, 40'h00_0000_0006});

        // R10 restart while busy
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h10); wr(3'd2, 8'h00); wr(3'd3, 8'h05); wr(3'd4, 8'h00);
        @(negedge clk);
        wr(3'd4, 8'h01);
        movf = 1;
        for (int k = 0; k < 4; k++) begin
            if (valid !== 1'b0) movf = 0;
            @(negedge clk);
        end
        if (valid !== 1'b0) movf = 0;
        @(negedge clk);
        if (valid !== 1'b1) movf = 0;
        check("R10 restart latency", {63'b0, movf}, 64'd1);
        rd_res(v); check("R10 new operands", {24'b0, v}, {24'b0, exp_mul(16'h0010, 16'h0105)});

        // R12 read gating and unused addresses
        @(negedge clk); addr = 3'd0; rd_en = 1'b0; #1;
        check("R12 rd_en low", {56'b0, rd_data}, 64'd0);
        rd(3'd6, b8); check("R12 addr6", {56'b0, b8}, 64'd0);
        rd(3'd7, b8); check("R12 addr7", {56'b0, b8}, 64'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule